// File: doc/BRIEF.md
# Sequential Sobel Gradient Magnitude Unit

This unit produces one edge-strength pixel per request from a grayscale image that has already been passed through a 3x3 mean filter. A controller gives it a pixel coordinate and a start pulse. The unit then walks the 3x3 neighbourhood around that coordinate through a single-port synchronous memory, one pixel per access. It folds each returned pixel into a horizontal and a vertical gradient using only shifts, additions and subtractions. It then writes the saturated magnitude to a result area of the same memory and pulses done.

One pixel costs exactly ten memory cycles: nine reads back to back and one write. The gradients are updated as each read word arrives, so the write comes in the cycle right after the last read. Neighbours that fall outside the image are replaced by the nearest edge pixel. Source and result areas are placed by base-address parameters, and pixels are stored row by row.

Top module: `sobel_mag_seq`

## Requirements
- R1: After reset, busy, done, mem_rd and mem_wr are all low.
- R2: A start seen while idle latches pix_x/pix_y. Reads are then issued for nine consecutive cycles, starting in the next cycle. A single write cycle follows directly. done is high for exactly one cycle, the cycle after the write, and busy is low again in that cycle. Read data is taken from mem_rdata one cycle after its read.
- R3: The nine reads visit the neighbourhood row by row: row offset -1, 0, +1, and within each row column offset -1, 0, +1. Each address is SRC_BASE + row*IMG_W + col.
- R4: A neighbour column below 0 or above IMG_W-1 is clamped to that edge, and rows are clamped the same way to 0..IMG_H-1.
- R5: With p(r,c) the pixel at row offset r-1 and column offset c-1, Gx = (p02+2p12+p22) - (p00+2p10+p20) and Gy = (p20+2p21+p22) - (p00+2p01+p02). The written value is |Gx|+|Gy|.
- R6: A magnitude above 255 is written as 255.
- R7: The write goes to DST_BASE + y*IMG_W + x for the latched (clamped) centre coordinate.
- R8: A start while busy is ignored. It causes no extra access, no extra done, and no change to the coordinate in use.
- R9: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one output pixel |
| pix_x | input | XW | Column of the centre pixel |
| pix_y | input | YW | Row of the centre pixel |
| busy | output | 1 | A pixel is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Read request this cycle |
| mem_wr | output | 1 | Write request this cycle |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | PIX_W | Result pixel to write |
| mem_rdata | input | PIX_W | Read data, valid one cycle after mem_rd |

## Verification
The corner pixels are driven so that clamping is visible. A unit that skipped clamping would issue addresses in a neighbouring row or outside the source area, and the recorded address sequence would be wrong. Ramps in both directions, including falling ones, exercise the sign handling: an unsigned or unabsolved gradient would give a value wrapped near 255 or a sum that is too small. A hard 0/255 edge pushes the magnitude to 1020 and catches a unit that truncates instead of saturating. A start issued mid-sequence with another coordinate exposes a unit that restarts, relatches or writes twice. Exact cycle counts catch a write delayed by a spare accumulate cycle.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    localparam int TAPS     = 9;
    localparam int TAP_W    = 4;
    localparam int LAST_TAP = TAPS - 1;

endpackage

// File: rtl/sobel_addr_gen.sv
module sobel_addr_gen #(
    parameter int IMG_W    = 100,
    parameter int IMG_H    = 100,
    parameter int XW       = 7,
    parameter int YW       = 7,
    parameter int AW       = 15,
    parameter int SRC_BASE = 0,
    parameter int DST_BASE = 10000
) (
    input  logic [XW-1:0] cx,
    input  logic [YW-1:0] cy,
    input  logic [3:0]    tap,
    input  logic          to_dst,
    output logic [AW-1:0] addr
);

    // Tap index -> offset: rows first, columns inside a row
    always_comb begin
        int dx;
        int dy;
        int nx;
        int ny;
        if (to_dst) begin
            dx = 0;
            dy = 0;
        end else begin
            dx = int'(tap % 4'd3) - 1;
            dy = int'(tap / 4'd3) - 1;
        end
        nx = int'(cx) + dx;
        ny = int'(cy) + dy;
        if (nx < 0)       nx = 0;
        if (nx > IMG_W-1) nx = IMG_W - 1;
        if (ny < 0)       ny = 0;
        if (ny > IMG_H-1) ny = IMG_H - 1;
        addr = AW'((to_dst ? DST_BASE : SRC_BASE) + ny * IMG_W + nx);
    end

endmodule

// File: rtl/sobel_tap_acc.sv
module sobel_tap_acc #(
    parameter int PIX_W = 8,
    parameter int GW    = 11
) (
    input  logic signed [GW-1:0] gx_cur,
    input  logic signed [GW-1:0] gy_cur,
    input  logic [3:0]           tap,
    input  logic [PIX_W-1:0]     pix,
    output logic signed [GW-1:0] gx_nxt,
    output logic signed [GW-1:0] gy_nxt
);

    logic signed [GW-1:0] p1;
    logic signed [GW-1:0] p2;

    assign p1 = GW'(pix);
    assign p2 = p1 <<< 1;

    // Weights are +-1 / +-2 only: shift and add, no multiplier
    always_comb begin
        gx_nxt = gx_cur;
        gy_nxt = gy_cur;
        case (tap)
            4'd0: begin gx_nxt = gx_cur - p1; gy_nxt = gy_cur - p1; end
            4'd1: begin                        gy_nxt = gy_cur - p2; end
            4'd2: begin gx_nxt = gx_cur + p1; gy_nxt = gy_cur - p1; end
            4'd3: begin gx_nxt = gx_cur - p2;                        end
            4'd5: begin gx_nxt = gx_cur + p2;                        end
            4'd6: begin gx_nxt = gx_cur - p1; gy_nxt = gy_cur + p1; end
            4'd7: begin                        gy_nxt = gy_cur + p2; end
            4'd8: begin gx_nxt = gx_cur + p1; gy_nxt = gy_cur + p1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/sobel_mag_sat.sv
module sobel_mag_sat #(
    parameter int PIX_W = 8,
    parameter int GW    = 11
) (
    input  logic signed [GW-1:0] gx,
    input  logic signed [GW-1:0] gy,
    output logic [PIX_W-1:0]     mag
);

    localparam int SW = GW + 1;
    localparam logic [SW-1:0] MAXV = SW'((1 << PIX_W) - 1);

    logic [GW-1:0] ax;
    logic [GW-1:0] ay;
    logic [SW-1:0] sum;

    assign ax  = gx[GW-1] ? GW'(-gx) : GW'(gx);
    assign ay  = gy[GW-1] ? GW'(-gy) : GW'(gy);
    assign sum = SW'(ax) + SW'(ay);
    assign mag = (sum > MAXV) ? MAXV[PIX_W-1:0] : sum[PIX_W-1:0];

endmodule

// File: rtl/sobel_mag_seq.sv
module sobel_mag_seq
    import sobel_pkg::*;
#(
    parameter int IMG_W    = 100,
    parameter int IMG_H    = 100,
    parameter int PIX_W    = 8,
    parameter int AW       = 15,
    parameter int SRC_BASE = 0,
    parameter int DST_BASE = IMG_W * IMG_H,
    parameter int XW       = $clog2(IMG_W),
    parameter int YW       = $clog2(IMG_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [XW-1:0]    pix_x,
    input  logic [YW-1:0]    pix_y,
    output logic             busy,
    output logic             done,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [PIX_W-1:0] mem_wdata,
    input  logic [PIX_W-1:0] mem_rdata
);

    // Gradient range is +-4*(2^PIX_W-1): three extra bits
    localparam int GW = PIX_W + 3;

    typedef struct packed {
        phase_e               ph;
        logic [TAP_W-1:0]     tap;
        logic                 rx_vld;
        logic [TAP_W-1:0]     rx_tap;
        logic [XW-1:0]        cx;
        logic [YW-1:0]        cy;
        logic signed [GW-1:0] gx;
        logic signed [GW-1:0] gy;
        logic                 done;
    } seq_t;

    seq_t st_d;
    seq_t st_q;

    logic signed [GW-1:0] gx_acc_d;
    logic signed [GW-1:0] gy_acc_d;

    sobel_tap_acc #(
        .PIX_W (PIX_W),
        .GW    (GW)
    ) u_acc (
        .gx_cur (st_q.gx),
        .gy_cur (st_q.gy),
        .tap    (st_q.rx_tap),
        .pix    (mem_rdata),
        .gx_nxt (gx_acc_d),
        .gy_nxt (gy_acc_d)
    );

    sobel_addr_gen #(
        .IMG_W    (IMG_W),
        .IMG_H    (IMG_H),
        .XW       (XW),
        .YW       (YW),
        .AW       (AW),
        .SRC_BASE (SRC_BASE),
        .DST_BASE (DST_BASE)
    ) u_addr (
        .cx     (st_q.cx),
        .cy     (st_q.cy),
        .tap    (st_q.tap),
        .to_dst (st_q.ph == PH_WRITE),
        .addr   (mem_addr)
    );

    // Write data uses the ninth word as it arrives
    sobel_mag_sat #(
        .PIX_W (PIX_W),
        .GW    (GW)
    ) u_sat (
        .gx  (gx_acc_d),
        .gy  (gy_acc_d),
        .mag (mem_wdata)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.rx_vld = 1'b0;
        if (st_q.rx_vld) begin
            st_d.gx = gx_acc_d;
            st_d.gy = gy_acc_d;
        end
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph  = PH_READ;
                    st_d.tap = '0;
                    st_d.cx  = pix_x;
                    st_d.cy  = pix_y;
                    st_d.gx  = '0;
                    st_d.gy  = '0;
                end
            end
            PH_READ: begin
                st_d.rx_vld = 1'b1;
                st_d.rx_tap = st_q.tap;
                if (st_q.tap == TAP_W'(LAST_TAP)) begin
                    st_d.ph = PH_WRITE;
                end else begin
                    st_d.tap = st_q.tap + 1'b1;
                end
            end
            PH_WRITE: begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.ph != PH_IDLE);
    assign done   = st_q.done;
    assign mem_rd = (st_q.ph == PH_READ);
    assign mem_wr = (st_q.ph == PH_WRITE);

endmodule

// File: rtl/sobel_mag_seq_chk.sv
module sobel_mag_seq_chk #(
    parameter int AW    = 15,
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [AW-1:0]    mem_addr,
    input logic [PIX_W-1:0] mem_wdata
);

    logic [3:0] rd_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt_q <= '0;
        end else if (start && !busy) begin
            rd_cnt_q <= '0;
        end else if (mem_rd) begin
            rd_cnt_q <= rd_cnt_q + 1'b1;
        end
    end

    // R9
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> mem_rd);

    // R2
    read_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_rd || mem_wr));

    // R2
    nine_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (rd_cnt_q == 4'd9));

    // R2
    write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (done && !busy && !mem_wr));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_wr) |=> busy);

endmodule

bind sobel_mag_seq sobel_mag_seq_chk #(.AW(AW), .PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/sim_sobel_mag_seq.sv
`timescale 1ns/1ps
module sim_sobel_mag_seq;

    localparam int W    = 8;
    localparam int H    = 6;
    localparam int AW   = 8;
    localparam int DSTB = 64;
    localparam int XW   = $clog2(W);
    localparam int YW   = $clog2(H);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [XW-1:0] pix_x = '0;
    logic [YW-1:0] pix_y = '0;
    logic          busy;
    logic          done;
    logic          mem_rd;
    logic          mem_wr;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;

    logic [7:0] mem [0:255];

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sobel_mag_seq #(
        .IMG_W (W), .IMG_H (H), .PIX_W (8), .AW (AW),
        .SRC_BASE (0), .DST_BASE (DSTB)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start (start),
        .pix_x (pix_x), .pix_y (pix_y), .busy (busy), .done (done),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );

    // Synchronous single-port memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int pat(input int kind, input int x, input int y);
        case (kind)
            0: return 77;
            1: return x * 10;
            2: return (H - 1 - y) * 12;
            3: return (x >= 4) ? 255 : 0;
            4: return x * 9 + y * 7;
            default: return (x * 37 + y * 91 + x * y * 13) & 255;
        endcase
    endfunction

    task automatic fill(input int kind);
        for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                mem[y * W + x] = 8'(pat(kind, x, y));
    endtask

    function automatic int src_at(input int x, input int y, input int dx, input int dy);
        return int'(mem[clampi(y + dy, 0, H - 1) * W + clampi(x + dx, 0, W - 1)]);
    endfunction

    function automatic int exp_mag(input int x, input int y);
        int gx;
        int gy;
        int m;
        gx = (src_at(x,y,1,-1) + 2*src_at(x,y,1,0) + src_at(x,y,1,1))
           - (src_at(x,y,-1,-1) + 2*src_at(x,y,-1,0) + src_at(x,y,-1,1));
        gy = (src_at(x,y,-1,1) + 2*src_at(x,y,0,1) + src_at(x,y,1,1))
           - (src_at(x,y,-1,-1) + 2*src_at(x,y,0,-1) + src_at(x,y,1,-1));
        m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
        return (m > 255) ? 255 : m;
    endfunction

    // One pixel request; optional stray start at cycle 4 with other coordinates
    task automatic run_pixel(input int x, input int y, input bit stray, input string name);
        int rd_n = 0;
        int wr_n = 0;
        int wr_cyc = -1;
        int done_n = 0;
        int done_cyc = -1;
        int wr_addr = -1;
        int wr_dat = -1;
        int exp_v;
        int rd_log [9];
        bit order_ok = 1;
        exp_v = exp_mag(x, y);
        @(negedge clk);
        pix_x = XW'(x);
        pix_y = YW'(y);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= 14; k++) begin
            if (stray && k == 4) begin
                start = 1'b1;
                pix_x = XW'(W - 1 - x);
                pix_y = YW'(H - 1 - y);
            end else begin
                start = 1'b0;
            end
            if (mem_rd) begin
                if (rd_n < 9) rd_log[rd_n] = int'(mem_addr);
                if (k != rd_n + 1) order_ok = 0;
                rd_n++;
            end
            if (mem_wr) begin
                wr_n++;
                wr_cyc = k;
                wr_addr = int'(mem_addr);
                wr_dat = int'(mem_wdata);
            end
            if (done) begin
                done_n++;
                done_cyc = k;
                check(!busy, {name, " R2 busy low at done"}, int'(busy), 0);
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(rd_n == 9 && order_ok, {name, " R2 nine consecutive reads"}, rd_n, 9);
        check(wr_n == 1 && wr_cyc == 10, {name, " R2 single write at cycle 10"}, wr_cyc, 10);
        check(done_n == 1 && done_cyc == 11, {name, " R2 done at cycle 11"}, done_cyc, 11);
        for (int t = 0; t < 9; t++) begin
            int ea;
            ea = clampi(y + t / 3 - 1, 0, H - 1) * W + clampi(x + t % 3 - 1, 0, W - 1);
            if (t < rd_n) check(rd_log[t] == ea, {name, " R3 R4 read address order"}, rd_log[t], ea);
        end
        check(wr_addr == DSTB + y * W + x, {name, " R7 write address"}, wr_addr, DSTB + y * W + x);
        check(wr_dat == exp_v, {name, " R5 R6 magnitude"}, wr_dat, exp_v);
        check(int'(mem[DSTB + y * W + x]) == exp_v, {name, " R7 stored result"},
              int'(mem[DSTB + y * W + x]), exp_v);
        if (stray) begin
            int oa;
            oa = DSTB + (H - 1 - y) * W + (W - 1 - x);
            check(int'(mem[oa]) == 8'hA5, {name, " R8 stray target untouched"}, int'(mem[oa]), 8'hA5);
            check(!busy && !mem_rd, {name, " R8 idle after run"}, int'(busy), 0);
        end
    endtask

    task automatic t_reset;
        check(!busy,   "R1 busy after reset",   int'(busy),   0);
        check(!done,   "R1 done after reset",   int'(done),   0);
        check(!mem_rd, "R1 mem_rd after reset", int'(mem_rd), 0);
        check(!mem_wr, "R1 mem_wr after reset", int'(mem_wr), 0);
    endtask

    task automatic t_flat;      fill(0); run_pixel(3, 2, 0, "flat");        endtask
    task automatic t_hramp;     fill(1); run_pixel(3, 2, 0, "hramp");       endtask
    task automatic t_vramp_neg; fill(2); run_pixel(4, 3, 0, "vramp_neg");   endtask
    task automatic t_saturate;  fill(3); run_pixel(4, 2, 0, "saturate");    endtask
    task automatic t_diag;      fill(4); run_pixel(2, 3, 0, "diag");        endtask
    task automatic t_corners;
        fill(5);
        run_pixel(0, 0, 0, "corner_tl");
        run_pixel(W - 1, H - 1, 0, "corner_br");
        run_pixel(W - 1, 0, 0, "corner_tr");
    endtask
    task automatic t_stray;     fill(5); run_pixel(2, 1, 1, "stray_start"); endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flat();
        t_hramp();
        t_vramp_neg();
        t_saturate();
        t_diag();
        t_corners();
        t_stray();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule